// File: doc/BRIEF.md
# Successive-Approximation A/D Conversion Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter inside a small microcontroller. Software writes a mode register to choose one of eight analog inputs and to request a conversion. The block then drives the analog multiplexer select and a trial code toward an external DAC and comparator. It reads back the comparator decision once per bit and keeps the finished code in a result register that software can read but not write.

A conversion request is a self-clearing start bit. After the request there is a fixed settling phase, and only at its end does the end-of-conversion flag drop. The eight bits are then resolved from the most significant down, each during an equal time slice. The whole sequence lasts a fixed number of system clocks, after which the result register is loaded and the end-of-conversion flag is raised. A new start request during a conversion abandons it and begins again from the top bit.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the result reads 0x7F, the mode register reads 0x00 and the trial code is 0x00.
- R2: A write to the mode register (`wr_sel`=0) loads `wr_data[6:4]` as the channel; from the next cycle on it appears on `mux_sel` and reads back in `mode_rd[6:4]`.
- R3: A mode write with `wr_data[3]`=1 starts a conversion; bit 3 of `mode_rd` always reads 0.
- R4: The end-of-conversion flag (`mode_rd[2]`) keeps its value for the first 16 clocks after the start write and reads 0 from the 16th rising edge after it.
- R5: Exactly 168 clocks after the start write the result register is loaded and `mode_rd[2]` reads 1.
- R6: Bits are resolved MSB first, 19 clocks each, after the 16-clock settling phase; a bit under trial is driven as 1 on `trial_code` with all lower bits 0; it is kept when `cmp_in` is 1 at the last clock of its slice and cleared otherwise, so the result equals the largest code not above the analog value.
- R7: Writes with `wr_sel`=1 (the result register) change nothing.
- R8: The result register changes only at the clock where the end-of-conversion flag rises; it never shows a partial code.
- R9: A start write during a conversion restarts it from the MSB with fresh timing; the flag stays 0 until the restarted conversion completes.
- R10: Channel and start may be given in the same write; the new channel is on `mux_sel` during the whole conversion.
- R11: Mode-register bits 7, 2, 1 and 0 are not writable; a write does not change the end-of-conversion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mode register, 1 result register (ignored) |
| wr_data | input | 8 | Write data |
| cmp_in | input | 1 | Comparator decision: 1 when the analog input is at or above the trial code |
| mode_rd | output | 8 | Mode register read value: channel [6:4], end-of-conversion flag [2] |
| result | output | 8 | Conversion result register |
| mux_sel | output | 3 | Analog multiplexer channel select |
| trial_code | output | 8 | Code driven to the DAC |

## Verification
With the start write sampled at rising edge T, the channel and start-bit read-back are due from T+1, the trial code 0x80 right after T, the flag falls at T+16, bit i is settled at T+16+19(i+1), and the result and flag rise together at T+168. The bench reference model counts rising edges since the last start write and updates its expected values at the same edges as the design; all outputs are compared at the falling edge, half a period after every update. The comparator is modelled from the design's own trial code against an analog value held by the bench, so restarts, analog changes and writes during a conversion are all followed edge by edge.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETTLE = 2'd1,
      PH_CONV   = 2'd2
   } sar_phase_e;

   localparam int MODE_W       = 8;
   localparam int MODE_CH_LSB  = 4;
   localparam int MODE_SOC_BIT = 3;
   localparam int MODE_EOC_BIT = 2;

   localparam logic SEL_MODE   = 1'b0;
   localparam logic SEL_RESULT = 1'b1;

endpackage

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
   import sar_adc_pkg::*;
#(
   parameter int BITS        = 8,
   parameter int SETTLE_CLKS = 16,
   parameter int SLICE_CLKS  = 19,
   localparam int IDX_W      = (BITS > 1) ? $clog2(BITS) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             settle_done,
   output logic             decide,
   output logic             done,
   output logic [IDX_W-1:0] bit_idx
);

   localparam int CNT_MAX = (SETTLE_CLKS > SLICE_CLKS) ? SETTLE_CLKS : SLICE_CLKS;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   sar_phase_e       phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] idx_q;

   assign settle_done = (phase_q == PH_SETTLE) && (cnt_q == CNT_W'(SETTLE_CLKS - 1)) && !start;
   assign decide      = (phase_q == PH_CONV) && (cnt_q == CNT_W'(SLICE_CLKS - 1)) && !start;
   assign done        = decide && (idx_q == IDX_W'(BITS - 1));
   assign bit_idx     = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
      end else if (start) begin
         phase_q <= PH_SETTLE;
         cnt_q   <= '0;
         idx_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_SETTLE: begin
               if (settle_done) begin
                  phase_q <= PH_CONV;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_CONV: begin
               if (done) begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
                  idx_q   <= '0;
               end else if (decide) begin
                  cnt_q <= '0;
                  idx_q <= idx_q + 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               cnt_q <= '0;
               idx_q <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/sar_adc_code.sv
module sar_adc_code #(
   parameter int BITS         = 8,
   localparam int IDX_W       = (BITS > 1) ? $clog2(BITS) : 1,
   localparam logic [BITS-1:0] RESULT_RST = {1'b0, {(BITS-1){1'b1}}}
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             decide,
   input  logic             done,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             cmp_in,
   output logic [BITS-1:0]  trial,
   output logic [BITS-1:0]  result
);

   logic [BITS-1:0] sar_q;
   logic [BITS-1:0] final_code;
   logic [BITS-1:0] result_q;

   for (genvar b = 0; b < BITS; b++) begin : g_bit
      localparam int STEP = BITS - 1 - b;
      logic bit_q;
      logic arm;

      if (b < BITS - 1) begin : g_arm
         assign arm = decide && (bit_idx == IDX_W'(STEP - 1));
      end else begin : g_top
         assign arm = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       bit_q <= 1'b0;
         else if (start)                                   bit_q <= (b == BITS - 1);
         else if (decide && (bit_idx == IDX_W'(STEP)))     bit_q <= cmp_in;
         else if (arm)                                     bit_q <= 1'b1;
      end

      assign sar_q[b] = bit_q;
   end

   assign final_code = {sar_q[BITS-1:1], cmp_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    result_q <= RESULT_RST;
      else if (done) result_q <= final_code;
   end

   assign trial  = sar_q;
   assign result = result_q;

endmodule

// File: rtl/sar_adc_mode.sv
module sar_adc_mode
   import sar_adc_pkg::*;
#(
   parameter int CH_W = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [MODE_W-1:0] wr_data,
   input  logic              settle_done,
   input  logic              done,
   output logic              start,
   output logic [CH_W-1:0]   chan,
   output logic [MODE_W-1:0] mode_rd
);

   logic            mode_wr;
   logic [CH_W-1:0] chan_q;
   logic            eoc_q;

   assign mode_wr = wr_en && (wr_sel == SEL_MODE);
   assign start   = mode_wr && wr_data[MODE_SOC_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       chan_q <= '0;
      else if (mode_wr) chan_q <= wr_data[MODE_CH_LSB +: CH_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           eoc_q <= 1'b0;
      else if (done)        eoc_q <= 1'b1;
      else if (settle_done) eoc_q <= 1'b0;
   end

   always_comb begin
      mode_rd                         = '0;
      mode_rd[MODE_CH_LSB +: CH_W]    = chan_q;
      mode_rd[MODE_EOC_BIT]           = eoc_q;
   end

   assign chan = chan_q;

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
   import sar_adc_pkg::*;
#(
   parameter int BITS        = 8,
   parameter int CH_W        = 3,
   parameter int SETTLE_CLKS = 16,
   parameter int CONV_CLKS   = 168
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [MODE_W-1:0] wr_data,
   input  logic              cmp_in,
   output logic [MODE_W-1:0] mode_rd,
   output logic [BITS-1:0]   result,
   output logic [CH_W-1:0]   mux_sel,
   output logic [BITS-1:0]   trial_code
);

   localparam int SLICE_CLKS = (CONV_CLKS - SETTLE_CLKS) / BITS;
   localparam int IDX_W      = (BITS > 1) ? $clog2(BITS) : 1;

   if (BITS < 2) begin : g_bad_bits
      $error("sar_adc_ctrl: BITS must be at least 2");
   end
   if (MODE_CH_LSB + CH_W > MODE_W) begin : g_bad_chan
      $error("sar_adc_ctrl: channel field does not fit the mode register");
   end
   if (SETTLE_CLKS < 1 || SLICE_CLKS < 1) begin : g_bad_time
      $error("sar_adc_ctrl: settle and slice lengths must be positive");
   end
   if ((CONV_CLKS - SETTLE_CLKS) % BITS != 0) begin : g_bad_split
      $error("sar_adc_ctrl: conversion time minus settle time must split evenly over the bits");
   end

   logic             start;
   logic             settle_done;
   logic             decide;
   logic             done;
   logic [IDX_W-1:0] bit_idx;

   sar_adc_mode #(.CH_W(CH_W)) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .settle_done (settle_done),
      .done        (done),
      .start       (start),
      .chan        (mux_sel),
      .mode_rd     (mode_rd)
   );

   sar_adc_seq #(
      .BITS        (BITS),
      .SETTLE_CLKS (SETTLE_CLKS),
      .SLICE_CLKS  (SLICE_CLKS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .settle_done (settle_done),
      .decide      (decide),
      .done        (done),
      .bit_idx     (bit_idx)
   );

   sar_adc_code #(.BITS(BITS)) u_code (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .decide  (decide),
      .done    (done),
      .bit_idx (bit_idx),
      .cmp_in  (cmp_in),
      .trial   (trial_code),
      .result  (result)
   );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
   import sar_adc_pkg::*;
#(
   parameter int BITS        = 8,
   parameter int CH_W        = 3,
   parameter int SETTLE_CLKS = 16,
   parameter int CONV_CLKS   = 168
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [MODE_W-1:0] wr_data,
   input logic [MODE_W-1:0] mode_rd,
   input logic [BITS-1:0]   result,
   input logic [CH_W-1:0]   mux_sel,
   input logic [BITS-1:0]   trial_code
);

   localparam int SW = $clog2(CONV_CLKS + 2) + 1;

   logic          soc_wr;
   logic [SW-1:0] since_q;

   assign soc_wr = wr_en && (wr_sel == SEL_MODE) && wr_data[MODE_SOC_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                           since_q <= '0;
      else if (soc_wr)                                      since_q <= SW'(1);
      else if (since_q != '0 && since_q <= SW'(CONV_CLKS))  since_q <= since_q + 1'b1;
   end

   assert_chan_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_MODE) |=>
         (mux_sel == $past(wr_data[MODE_CH_LSB +: CH_W])) &&
         (mode_rd[MODE_CH_LSB +: CH_W] == $past(wr_data[MODE_CH_LSB +: CH_W])));

   assert_soc_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      soc_wr |=> !mode_rd[MODE_SOC_BIT]);

   assert_eoc_fall_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mode_rd[MODE_EOC_BIT]) |-> (since_q == SW'(SETTLE_CLKS + 1)));

   assert_eoc_rise_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_rd[MODE_EOC_BIT]) |-> (since_q == SW'(CONV_CLKS + 1)));

   assert_msb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      soc_wr |=> (trial_code == {1'b1, {(BITS-1){1'b0}}}));

   assert_result_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_RESULT && mode_rd[MODE_EOC_BIT]) |=> $stable(result));

   assert_result_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (result != $past(result)) |-> $rose(mode_rd[MODE_EOC_BIT]));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
   .BITS        (BITS),
   .CH_W        (CH_W),
   .SETTLE_CLKS (SETTLE_CLKS),
   .CONV_CLKS   (CONV_CLKS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .wr_data    (wr_data),
   .mode_rd    (mode_rd),
   .result     (result),
   .mux_sel    (mux_sel),
   .trial_code (trial_code)
);

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;

   localparam int SETTLE = 16;
   localparam int CONV   = 168;
   localparam int SLICE  = (CONV - SETTLE) / 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       cmp_in;
   logic [7:0] mode_rd;
   logic [7:0] result;
   logic [2:0] mux_sel;
   logic [7:0] trial_code;

   int analog = 0;
   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   assign cmp_in = (analog >= int'(trial_code));

   sar_adc_ctrl u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .cmp_in     (cmp_in),
      .mode_rd    (mode_rd),
      .result     (result),
      .mux_sel    (mux_sel),
      .trial_code (trial_code)
   );

   // reference model: counts rising edges since the last start write
   int         m_since = -1;
   logic [7:0] exp_res = 8'h7F;
   logic       exp_eoc = 1'b0;
   logic [2:0] exp_chan = 3'd0;
   logic [7:0] m_sar = 8'h00;

   always @(posedge clk) begin
      int step;
      int pos;
      if (!rst_n) begin
         m_since  = -1;
         exp_res  = 8'h7F;
         exp_eoc  = 1'b0;
         exp_chan = 3'd0;
         m_sar    = 8'h00;
      end else begin
         if (wr_en && !wr_sel) exp_chan = wr_data[6:4];
         if (wr_en && !wr_sel && wr_data[3]) begin
            m_since = 0;
            m_sar   = 8'h80;
         end else if (m_since >= 0) begin
            m_since++;
            if (m_since == SETTLE) exp_eoc = 1'b0;
            if (m_since > SETTLE && (m_since - SETTLE) % SLICE == 0) begin
               step = (m_since - SETTLE) / SLICE - 1;
               pos  = 7 - step;
               if (analog < int'(m_sar)) m_sar[pos] = 1'b0;
               if (pos > 0) m_sar[pos-1] = 1'b1;
               if (step == 7) begin
                  exp_res = m_sar;
                  exp_eoc = 1'b1;
                  m_since = -1;
               end
            end
         end
      end
   end

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(result == exp_res, "R5/R8 result", result, exp_res);
         chk(mode_rd[2] == exp_eoc, "R4/R5/R9 eoc flag", mode_rd[2], exp_eoc);
         chk(mux_sel == exp_chan, "R2/R10 mux_sel", mux_sel, exp_chan);
         chk(mode_rd == {1'b0, exp_chan, 1'b0, exp_eoc, 2'b00}, "R3/R11 mode_rd",
             mode_rd, {1'b0, exp_chan, 1'b0, exp_eoc, 2'b00});
         chk(trial_code == m_sar, "R6 trial_code", trial_code, m_sar);
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = 8'h00;
   endtask

   task automatic convert(input int val, input logic [7:0] mode);
      analog = val;
      reg_wr(1'b0, mode);
      cycles(CONV + 2);
      chk(result == 8'(val), "R6 final code", result, val);
      chk(mode_rd[2] == 1'b1, "R5 eoc set", mode_rd[2], 1);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      cycles(4);
      rst_n = 1'b1;
      cycles(1);
      chk(result == 8'h7F, "R1 reset result", result, 8'h7F);
      chk(mode_rd == 8'h00, "R1 reset mode", mode_rd, 8'h00);
      chk(trial_code == 8'h00, "R1 reset trial", trial_code, 8'h00);

      // R10: channel 3 and start in the same write
      convert(8'hA5, 8'h38);
      chk(mux_sel == 3'd3, "R10 channel", mux_sel, 3);
      convert(0, 8'h08);
      convert(255, 8'h78);
      convert(128, 8'h18);
      convert(127, 8'h28);

      // R7: result write while idle and during a conversion
      reg_wr(1'b1, 8'h12);
      cycles(2);
      chk(result == 8'h7F, "R7 idle write ignored", result, 8'h7F);
      analog = 8'h5A;
      reg_wr(1'b0, 8'h48);
      cycles(40);
      reg_wr(1'b1, 8'hFF);
      chk(result == 8'h7F, "R7 busy write ignored", result, 8'h7F);
      reg_wr(1'b0, 8'h60);   // R2: channel change mid-conversion, no start
      cycles(CONV);
      chk(result == 8'h5A, "R7/R8 code after writes", result, 8'h5A);

      // R9: restart in the middle of a conversion
      analog = 8'h3C;
      reg_wr(1'b0, 8'h18);
      cycles(60);
      analog = 8'hC3;
      reg_wr(1'b0, 8'h58);
      cycles(100);
      chk(mode_rd[2] == 1'b0, "R9 eoc low after restart", mode_rd[2], 0);
      chk(result == 8'h5A, "R9 no partial result", result, 8'h5A);
      cycles(80);
      chk(result == 8'hC3, "R9 restarted code", result, 8'hC3);

      // R11: read-only bits, eoc not writable
      reg_wr(1'b0, 8'h87);
      cycles(1);
      chk(mode_rd == 8'h04, "R11 read-only bits", mode_rd, 8'h04);

      // R4: start while eoc high holds the flag through the settle phase
      analog = 8'h01;
      reg_wr(1'b0, 8'h08);
      cycles(SETTLE - 3);
      chk(mode_rd[2] == 1'b1, "R4 eoc held during settle", mode_rd[2], 1);
      cycles(4);
      chk(mode_rd[2] == 1'b0, "R4 eoc cleared", mode_rd[2], 0);
      cycles(CONV);
      chk(result == 8'h01, "R6 small code", result, 8'h01);

      summary();
      $finish;
   end

endmodule